// File: doc/BRIEF.md
# Five-Input Prioritised Interrupt Acceptance Unit

This unit sits beside a small processor core and decides, at each instruction boundary, whether an interrupt is taken and which one. It watches five request lines: a non-maskable line, a latched rising-edge line, two level lines that carry fixed vectors, and a general level line whose service address the requesting device supplies after an acknowledge. Each line has its own detection rule. Three per-line masks and one global enable decide which requests may be accepted. A fixed priority then picks a single winner.

When the core strobes the instruction-boundary input and an eligible request is present, the unit raises a one-cycle taken pulse in the next cycle. With that pulse it gives a source code and either a 16-bit vector address or, for the general line, an acknowledge pulse. Saving the program counter and jumping are left to the core. A five-bit control word sets the masks and can drop the edge latch. An eight-bit status word always shows the masks, the global enable and the pending lines.

Top module: `irq_accept_unit`

## Requirements
- R1: After synchronous reset, take, gen_ack, take_src and vec_addr are 0, the global enable is 0 and all three masks are 1. With all request inputs low, status reads 8'h07.
- R2: The non-maskable line is accepted only after a low-to-high transition, and only if it is still high at the boundary. It is not accepted again while it stays high. It ignores the global enable and the masks. Its source code is 1 and its vector is 16'h0024.
- R3: A rising edge on edge_req is latched, so it is accepted even if the input has dropped. Its source code is 2 and its vector is 16'h003C. Accepting it clears the latch (status bit 4).
- R4: lvl_hi_req (source code 3, vector 16'h0034) and lvl_lo_req (source code 4, vector 16'h002C) are accepted only while they are high at the boundary edge.
- R5: gen_req is level-sensitive and gated by the global enable only. When it is accepted, take_src is 5, vec_addr is 0 and gen_ack pulses together with take.
- R6: When several requests are eligible at once, the winner is chosen in this order: non-maskable, edge, high level, low level, general.
- R7: A request is accepted only when insn_boundary is 1 at a clock edge. take is then 1 during the following cycle only. With no acceptance, take_src and vec_addr read 0.
- R8: cmd_enable sets the global enable and cmd_disable clears it. Disable wins if both are high. Accepting any source other than the non-maskable one clears the enable. Accepting the non-maskable source leaves the enable unchanged.
- R9: A write of mask_wdata with bit 3 = 1 loads masks from bits 2:0 (bit 0 edge, bit 1 high level, bit 2 low level, 1 = blocked). With bit 3 = 0 the masks are unchanged. Bit 4 = 1 clears the edge latch.
- R10: status bit 7 is the non-maskable pending flag, bit 6 the lvl_lo_req input, bit 5 the lvl_hi_req input, bit 4 the edge latch, bit 3 the global enable and bits 2:0 the masks.
- R11: A masked edge request stays latched and visible in status, and is accepted once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request (edge, then held) |
| edge_req | input | 1 | Latched rising-edge vectored request |
| lvl_hi_req | input | 1 | Higher level-sensitive vectored request |
| lvl_lo_req | input | 1 | Lower level-sensitive vectored request |
| gen_req | input | 1 | General non-vectored level request |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| cmd_enable | input | 1 | Set global enable |
| cmd_disable | input | 1 | Clear global enable |
| mask_wr | input | 1 | Control word write strobe |
| mask_wdata | input | 5 | Control word: masks, apply bit, latch clear |
| take | output | 1 | Interrupt accepted (one-cycle pulse) |
| take_src | output | 3 | Accepted source code |
| vec_addr | output | 16 | Vector address of accepted source |
| gen_ack | output | 1 | Acknowledge for the general request |
| status | output | 8 | Masks, enable and pending flags |

## Verification
The assertions assume that every request input is synchronous to clk. They also assume that a requesting device holds the non-maskable and level lines until it sees take, and that the core never strobes insn_boundary during reset. The stimulus changes every input a fixed delay after a rising edge. It keeps the level lines up through each boundary edge it aims to hit and drops them only after the result has been sampled. It runs a full sweep over every combination of the five requests, the eight mask patterns and both enable states. Before each case it clears the latch and drops every line for long enough that no earlier edge is carried into the next case.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int NUM_MSK   = 3;
    localparam int CTRL_W    = NUM_MSK + 2;
    localparam int CW_APPLY  = NUM_MSK;
    localparam int CW_CLRLAT = NUM_MSK + 1;
    localparam int STAT_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int SRC_W     = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_EDGE = 3'd2,
        SRC_HI   = 3'd3,
        SRC_LO   = 3'd4,
        SRC_GEN  = 3'd5
    } irq_src_e;

    localparam logic [ADDR_W-1:0] VEC_NMI  = 16'h0024;
    localparam logic [ADDR_W-1:0] VEC_EDGE = 16'h003C;
    localparam logic [ADDR_W-1:0] VEC_HI   = 16'h0034;
    localparam logic [ADDR_W-1:0] VEC_LO   = 16'h002C;

    typedef struct packed {
        logic nmi;
        logic edg;
        logic hi;
        logic lo;
        logic gen;
    } irq_pend_s;

    function automatic irq_src_e pick_src(input irq_pend_s p);
        if (p.nmi)      return SRC_NMI;
        else if (p.edg) return SRC_EDGE;
        else if (p.hi)  return SRC_HI;
        else if (p.lo)  return SRC_LO;
        else if (p.gen) return SRC_GEN;
        else            return SRC_NONE;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_of(input irq_src_e s);
        case (s)
            SRC_NMI:  return VEC_NMI;
            SRC_EDGE: return VEC_EDGE;
            SRC_HI:   return VEC_HI;
            SRC_LO:   return VEC_LO;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter bit HOLD_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic clr,
    output logic armed,
    output logic pend
);

    logic prev;
    logic nxt;
    logic rise;

    assign rise = req & ~prev;

    generate
        if (HOLD_LEVEL) begin : g_hold
            // request must stay high after its edge, otherwise the arm is lost
            always_comb nxt = (armed | rise) & req & ~clr;
            assign pend = armed & req;
        end else begin : g_latch
            always_comb nxt = (armed | rise) & ~clr;
            assign pend = armed;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            armed <= 1'b0;
        end else begin
            prev  <= req;
            armed <= nxt;
        end
    end

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_accept_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_en,
    input  logic               cmd_dis,
    input  logic               acc_maskable,
    input  logic               msk_wr,
    input  logic               msk_apply,
    input  logic [NUM_MSK-1:0] msk_bits,
    output logic               ie,
    output logic [NUM_MSK-1:0] msk
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie <= 1'b0;
        end else if (acc_maskable || cmd_dis) begin
            ie <= 1'b0;
        end else if (cmd_en) begin
            ie <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msk <= '1;
        end else if (msk_wr && msk_apply) begin
            for (int i = 0; i < NUM_MSK; i++) begin
                msk[i] <= msk_bits[i];
            end
        end
    end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_accept_pkg::*;
(
    input  irq_pend_s         pend,
    output irq_src_e          src,
    output logic [ADDR_W-1:0] vec
);

    always_comb begin
        src = pick_src(pend);
        vec = vec_of(src);
    end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_req,
    input  logic              edge_req,
    input  logic              lvl_hi_req,
    input  logic              lvl_lo_req,
    input  logic              gen_req,
    input  logic              insn_boundary,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              mask_wr,
    input  logic [CTRL_W-1:0] mask_wdata,
    output logic              take,
    output logic [SRC_W-1:0]  take_src,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              gen_ack,
    output logic [STAT_W-1:0] status
);

    logic               nmi_armed, nmi_pend;
    logic               edg_armed, edg_pend;
    logic               ie;
    logic [NUM_MSK-1:0] msk;
    irq_pend_s          elig;
    irq_src_e           sel_src;
    logic [ADDR_W-1:0]  sel_vec;
    logic               accept;
    logic               clr_nmi, clr_edg;

    irq_edge_capture #(.HOLD_LEVEL(1'b1)) u_nmi (
        .clk   (clk),
        .rst   (rst),
        .req   (nmi_req),
        .clr   (clr_nmi),
        .armed (nmi_armed),
        .pend  (nmi_pend)
    );

    irq_edge_capture #(.HOLD_LEVEL(1'b0)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .req   (edge_req),
        .clr   (clr_edg),
        .armed (edg_armed),
        .pend  (edg_pend)
    );

    irq_enable_regs u_en (
        .clk          (clk),
        .rst          (rst),
        .cmd_en       (cmd_enable),
        .cmd_dis      (cmd_disable),
        .acc_maskable (accept && (sel_src != SRC_NMI)),
        .msk_wr       (mask_wr),
        .msk_apply    (mask_wdata[CW_APPLY]),
        .msk_bits     (mask_wdata[NUM_MSK-1:0]),
        .ie           (ie),
        .msk          (msk)
    );

    always_comb begin
        elig.nmi = nmi_pend;
        elig.edg = edg_pend   & ~msk[0] & ie;
        elig.hi  = lvl_hi_req & ~msk[1] & ie;
        elig.lo  = lvl_lo_req & ~msk[2] & ie;
        elig.gen = gen_req    & ie;
    end

    irq_prio_sel u_sel (
        .pend (elig),
        .src  (sel_src),
        .vec  (sel_vec)
    );

    assign accept  = insn_boundary && (sel_src != SRC_NONE);
    assign clr_nmi = accept && (sel_src == SRC_NMI);
    assign clr_edg = (accept && (sel_src == SRC_EDGE)) ||
                     (mask_wr && mask_wdata[CW_CLRLAT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            take_src <= SRC_NONE;
            vec_addr <= '0;
            gen_ack  <= 1'b0;
        end else begin
            take     <= accept;
            take_src <= accept ? sel_src : SRC_NONE;
            vec_addr <= accept ? sel_vec : '0;
            gen_ack  <= accept && (sel_src == SRC_GEN);
        end
    end

    assign status = {nmi_pend, lvl_lo_req, lvl_hi_req, edg_armed, ie, msk};

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
    import irq_accept_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              insn_boundary,
    input logic              nmi_req,
    input logic              mask_wr,
    input logic [CTRL_W-1:0] mask_wdata,
    input logic              take,
    input logic [SRC_W-1:0]  take_src,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              gen_ack,
    input logic [STAT_W-1:0] status
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!take && status[3:0] == 4'b0111)); // R1

    AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
        (take && take_src == 3'd1) |-> $past(nmi_req)); // R2

    AST_EDGE_LATCH_DROPS: assert property (@(posedge clk) disable iff (rst)
        (take && take_src == 3'd2) |-> !status[4]); // R3

    AST_GEN_ACK_NO_VEC: assert property (@(posedge clk) disable iff (rst)
        gen_ack |-> (take && take_src == 3'd5 && vec_addr == '0)); // R5

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(insn_boundary)); // R7

    AST_MASKABLE_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
        (take && take_src != 3'd1) |-> !status[3]); // R8

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !($past(mask_wr) && $past(mask_wdata[CW_APPLY])) |->
            status[2:0] == $past(status[2:0])); // R9

endmodule

bind irq_accept_unit irq_accept_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .nmi_req       (nmi_req),
    .mask_wr       (mask_wr),
    .mask_wdata    (mask_wdata),
    .take          (take),
    .take_src      (take_src),
    .vec_addr      (vec_addr),
    .gen_ack       (gen_ack),
    .status        (status)
);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 0, edge_req = 0, lvl_hi_req = 0, lvl_lo_req = 0, gen_req = 0;
    logic        insn_boundary = 0, cmd_enable = 0, cmd_disable = 0, mask_wr = 0;
    logic [4:0]  mask_wdata = '0;
    logic        take;
    logic [2:0]  take_src;
    logic [15:0] vec_addr;
    logic        gen_ack;
    logic [7:0]  status;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_accept_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .nmi_req       (nmi_req),
        .edge_req      (edge_req),
        .lvl_hi_req    (lvl_hi_req),
        .lvl_lo_req    (lvl_lo_req),
        .gen_req       (gen_req),
        .insn_boundary (insn_boundary),
        .cmd_enable    (cmd_enable),
        .cmd_disable   (cmd_disable),
        .mask_wr       (mask_wr),
        .mask_wdata    (mask_wdata),
        .take          (take),
        .take_src      (take_src),
        .vec_addr      (vec_addr),
        .gen_ack       (gen_ack),
        .status        (status)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic bstep();
        insn_boundary = 1'b1;
        step();
        insn_boundary = 1'b0;
    endtask

    task automatic wr_mask(input logic [4:0] v);
        mask_wr = 1'b1;
        mask_wdata = v;
        step();
        mask_wr = 1'b0;
        mask_wdata = '0;
    endtask

    task automatic do_en();
        cmd_enable = 1'b1;
        step();
        cmd_enable = 1'b0;
    endtask

    task automatic do_dis();
        cmd_disable = 1'b1;
        step();
        cmd_disable = 1'b0;
    endtask

    task automatic drop_all();
        nmi_req = 0; edge_req = 0; lvl_hi_req = 0; lvl_lo_req = 0; gen_req = 0;
    endtask

    function automatic int exp_vec(input int s);
        case (s)
            1: return 32'h0024;
            2: return 32'h003C;
            3: return 32'h0034;
            4: return 32'h002C;
            default: return 0;
        endcase
    endfunction

    task automatic chk_take(input int es, input string rq);
        chk(take == (es != 0), rq, int'(take), int'(es != 0));
        chk(int'(take_src) == es, rq, int'(take_src), es);
        chk(int'(vec_addr) == exp_vec(es), rq, int'(vec_addr), exp_vec(es));
        chk(gen_ack == (es == 5), rq, int'(gen_ack), int'(es == 5));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk(status == 8'h07, "R1 status", int'(status), 32'h07);
        chk_take(0, "R1 outputs");

        // R7 no acceptance without boundary, R4 high level vector
        do_en();
        wr_mask(5'h08);
        lvl_hi_req = 1;
        repeat (3) step();
        chk(take == 1'b0, "R7 no boundary", int'(take), 0);
        bstep();
        chk_take(3, "R4 high level");
        step();
        chk(take == 1'b0, "R7 single pulse", int'(take), 0);
        chk(status[3] == 1'b0, "R8 ie cleared", int'(status[3]), 0);
        bstep();
        chk(take == 1'b0, "R8 blocked after clear", int'(take), 0);
        lvl_hi_req = 0;
        step();

        // R2 non-maskable: dropped before boundary, then held, then no retake
        nmi_req = 1; step();
        nmi_req = 0; step();
        bstep();
        chk(take == 1'b0, "R2 dropped edge", int'(take), 0);
        step();
        nmi_req = 1; step();
        bstep();
        chk_take(1, "R2 held edge");
        chk(status[3] == 1'b0, "R8 nmi keeps ie", int'(status[3]), 0);
        bstep();
        chk(take == 1'b0, "R2 no retake", int'(take), 0);
        nmi_req = 0; step();

        // R3 edge latched after drop
        do_en();
        edge_req = 1; step();
        edge_req = 0; step(); step();
        bstep();
        chk_take(2, "R3 edge latched");
        chk(status[4] == 1'b0, "R3 latch cleared", int'(status[4]), 0);

        // R4 level dropped is lost
        do_en();
        lvl_lo_req = 1; step();
        lvl_lo_req = 0;
        bstep();
        chk(take == 1'b0, "R4 level dropped", int'(take), 0);

        // R9 apply bit
        wr_mask(5'h07);
        chk(status[2:0] == 3'b000, "R9 no apply", int'(status[2:0]), 0);
        wr_mask(5'h0F);
        chk(status[2:0] == 3'b111, "R9 apply all", int'(status[2:0]), 7);
        wr_mask(5'h0A);
        chk(status[2:0] == 3'b010, "R9 apply pattern", int'(status[2:0]), 2);

        // R8 disable wins
        cmd_enable = 1; cmd_disable = 1; step();
        cmd_enable = 0; cmd_disable = 0;
        chk(status[3] == 1'b0, "R8 disable wins", int'(status[3]), 0);
        do_en();
        chk(status[3] == 1'b1, "R8 enable", int'(status[3]), 1);

        // R11 masked edge kept, taken after unmask
        wr_mask(5'h09);
        edge_req = 1; step();
        edge_req = 0; step();
        bstep();
        chk(take == 1'b0, "R11 masked edge", int'(take), 0);
        chk(status[4] == 1'b1, "R11 latch kept", int'(status[4]), 1);
        wr_mask(5'h08);
        bstep();
        chk_take(2, "R11 unmasked edge");
        chk(status[4] == 1'b0, "R11 latch cleared", int'(status[4]), 0);

        // R9 latch clear bit without apply
        do_en();
        wr_mask(5'h09);
        edge_req = 1; step();
        edge_req = 0; step();
        chk(status[4] == 1'b1, "R9 latch set", int'(status[4]), 1);
        wr_mask(5'h10);
        chk(status[4] == 1'b0, "R9 latch clear", int'(status[4]), 0);
        chk(status[2:0] == 3'b001, "R9 clear keeps masks", int'(status[2:0]), 1);

        // R10 status layout
        wr_mask(5'h0D);
        do_dis();
        nmi_req = 1; edge_req = 1; lvl_hi_req = 1; lvl_lo_req = 0;
        step();
        chk(status == 8'hB5, "R10 layout", int'(status), 32'hB5);
        drop_all();
        step();
        chk(status == 8'h15, "R10 after drop", int'(status), 32'h15);

        // sweep: every request combination, mask pattern and enable state
        for (int c = 0; c < 32; c++) begin
            for (int m = 0; m < 8; m++) begin
                for (int e = 0; e < 2; e++) begin
                    int es;
                    int eie;
                    drop_all();
                    wr_mask(5'h18 | 5'(m));
                    if (e != 0) do_en(); else do_dis();
                    step();
                    nmi_req = c[4]; edge_req = c[3]; lvl_hi_req = c[2];
                    lvl_lo_req = c[1]; gen_req = c[0];
                    step();
                    bstep();
                    if (c[4])                             es = 1;
                    else if (e != 0 && c[3] && !m[0])     es = 2;
                    else if (e != 0 && c[2] && !m[1])     es = 3;
                    else if (e != 0 && c[1] && !m[2])     es = 4;
                    else if (e != 0 && c[0])              es = 5;
                    else                                  es = 0;
                    chk_take(es, "R6 sweep priority");
                    eie = (es == 0 || es == 1) ? e : 0;
                    chk(int'(status[3]) == eie, "R8 sweep ie", int'(status[3]), eie);
                    drop_all();
                    step();
                    chk(take == 1'b0, "R7 sweep pulse end", int'(take), 0);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule